// File: doc/BRIEF.md
# Store and Exchange Merge Unit

This datapath block turns a store-class operation of a 32-bit machine into one memory write. The write carries a full data word and four byte-lane enables. The machine addresses memory in 16-bit halfwords. The block is given an operation code, the source register value, the current contents of the memory word that holds the target halfword, and a select that picks one halfword of that word. It merges the register bits into the correct lanes and copies the lanes it does not write from memory, so the write data is always a complete word. Bits are numbered with bit 0 as the most significant bit. Register bits 0–15 are `op_reg[31:16]`, bits 16–31 are `op_reg[15:0]`, and bits 24–31 are `op_reg[7:0]`.

For each operation the block reports whether the excess indicator is updated and what its new value is. The excess check tells whether the register value can be held in one signed halfword. Exchanges swap a register with memory. They run as a locked two-cycle sequence that cannot be split: a read phase, then a write phase. In the write phase the block writes the register to memory and returns the old memory contents for the register file to load. While the lock is held, interrupt requests are deferred.

Top module: `store_xchg_merge`

## Requirements
- R1: After reset, `wr_en`, `reg_we`, `flag_we`, `excess` and `lock` are 0 and `op_ready` is 1.
- R2: Code 26h writes `op_reg` unchanged with `wr_be`=1111 and `flag_we`=1. Its outputs appear in the cycle after the operation is accepted and last for one cycle. Carry and overflow are never produced.
- R3: When the indicator is updated, `excess` is 1 exactly when `op_reg[31:15]` is neither all zeros nor all ones.
- R4: Code 66h writes `op_reg[15:0]` into the selected halfword. `op_hsel`=0 selects `[31:16]` with `wr_be`=1100, and `op_hsel`=1 selects `[15:0]` with `wr_be`=0011. The other halfword of `wr_data` equals `mem_rdata`, and `flag_we`=1.
- R5: Code 64h behaves like R4 but writes `op_reg[31:16]`.
- R6: Code 25h writes `op_reg[7:0]` into the upper byte of the selected halfword. That is lane 3 (`wr_be`=1000) when `op_hsel`=0 and lane 1 (`wr_be`=0010) when `op_hsel`=1. All other lanes equal `mem_rdata`, and `flag_we`=0.
- R7: Code 65h writes `op_reg[7:0]` into the lower byte of the selected halfword. That is lane 2 (`wr_be`=0100) when `op_hsel`=0 and lane 0 (`wr_be`=0001) when `op_hsel`=1. All other lanes equal `mem_rdata`, and `flag_we`=0.
- R8: Code 27h writes a zero word with `wr_be`=1111. Code 67h zeroes only the selected halfword, with the halfword enables of R4, and keeps the other halfword. Neither updates the indicator.
- R9: Code 6Eh raises `lock` for exactly two cycles, starting the cycle after it is accepted. `mem_rdata` is sampled at the end of the first locked cycle. In the second locked cycle the block writes `op_reg[15:0]` into the selected halfword and asserts `reg_we` with the old halfword sign-extended to 32 bits. `excess` there follows R3 for the register value taken at acceptance.
- R10: Code 2Eh follows the R9 timing. It writes the whole register with `wr_be`=1111 and returns the whole old memory word on `reg_wdata`, with excess as in R3.
- R11: `irq_take` is 0 while `lock` is 1. A request present in any locked cycle is held and reaches `irq_take` in the first cycle after `lock` falls. When unlocked, `irq_take` follows `irq_req` in the same cycle.
- R12: `op_ready` is 0 while an exchange is in progress. Any code not listed above produces no write, no flag update and no register return.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | Operation presented this cycle |
| op_ready | output | 1 | Block can accept an operation |
| op_code | input | 8 | Function code |
| op_reg | input | 32 | Source register value |
| op_hsel | input | 1 | Halfword select: 0 for `[31:16]`, 1 for `[15:0]` |
| mem_rdata | input | 32 | Current memory word holding the target halfword |
| wr_en | output | 1 | Memory write strobe |
| wr_data | output | 32 | Merged write word |
| wr_be | output | 4 | Byte enables, bit 3 is the most significant lane |
| flag_we | output | 1 | Excess indicator update strobe |
| excess | output | 1 | New excess indicator value |
| reg_we | output | 1 | Exchange return strobe |
| reg_wdata | output | 32 | Value returned to the register |
| lock | output | 1 | Uninterruptible exchange window |
| irq_req | input | 1 | Interrupt request |
| irq_take | output | 1 | Interrupt may be taken now |

## Verification
The assertions assume that `mem_rdata` holds the addressed word in the cycle an operation is accepted and again through the first locked cycle of an exchange. They also assume that operations are presented only while `op_ready` is high. The stimulus respects both. It drives every operation on a falling edge while the block is idle, keeps memory constant from acceptance through the read phase, and drops `op_valid` after a single accepting edge. Interrupt pulses are placed inside and outside the locked window to exercise both the deferral and the pass-through behaviour.

// File: rtl/store_xchg_merge.sv
module store_xchg_merge #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          op_valid,
  output logic          op_ready,
  input  logic [7:0]    op_code,
  input  logic [DW-1:0] op_reg,
  input  logic          op_hsel,
  input  logic [DW-1:0] mem_rdata,
  output logic          wr_en,
  output logic [DW-1:0] wr_data,
  output logic [3:0]    wr_be,
  output logic          flag_we,
  output logic          excess,
  output logic          reg_we,
  output logic [DW-1:0] reg_wdata,
  output logic          lock,
  input  logic          irq_req,
  output logic          irq_take
);
  localparam int HW = DW / 2;

  typedef enum logic [1:0] {S_IDLE, S_RD, S_WR} st_t;
  st_t st;

  logic [DW-1:0] reg_q;
  logic          hsel_q, full_q, exc_q, irq_hold;

  function automatic logic [DW-1:0] put16(input logic [DW-1:0] w, input logic hs, input logic [HW-1:0] h);
    return hs ? {w[DW-1:HW], h} : {h, w[HW-1:0]};
  endfunction

  function automatic logic [DW-1:0] put8(input logic [DW-1:0] w, input logic [1:0] lane, input logic [7:0] b);
    logic [DW-1:0] r;
    r = w;
    r[lane*8 +: 8] = b;
    return r;
  endfunction

  wire       accept = op_valid & op_ready;
  wire       fits   = (&op_reg[DW-1:HW-1]) | ~(|op_reg[DW-1:HW-1]);
  wire [3:0] hbe    = op_hsel ? 4'b0011 : 4'b1100;
  wire [1:0] up_ln  = {~op_hsel, 1'b1};
  wire [1:0] lo_ln  = {~op_hsel, 1'b0};

  logic [DW-1:0] n_data;
  logic [3:0]    n_be;
  logic          n_wr, n_fwe, n_xchg;

  always_comb begin
    n_data = mem_rdata;
    n_be   = 4'b0000;
    n_wr   = 1'b0;
    n_fwe  = 1'b0;
    n_xchg = 1'b0;
    case (op_code)
      8'h26: begin n_data = op_reg; n_be = 4'b1111; n_wr = 1'b1; n_fwe = 1'b1; end
      8'h66: begin n_data = put16(mem_rdata, op_hsel, op_reg[HW-1:0]); n_be = hbe; n_wr = 1'b1; n_fwe = 1'b1; end
      8'h64: begin n_data = put16(mem_rdata, op_hsel, op_reg[DW-1:HW]); n_be = hbe; n_wr = 1'b1; n_fwe = 1'b1; end
      8'h25: begin n_data = put8(mem_rdata, up_ln, op_reg[7:0]); n_be = 4'b0001 << up_ln; n_wr = 1'b1; end
      8'h65: begin n_data = put8(mem_rdata, lo_ln, op_reg[7:0]); n_be = 4'b0001 << lo_ln; n_wr = 1'b1; end
      8'h27: begin n_data = '0; n_be = 4'b1111; n_wr = 1'b1; end
      8'h67: begin n_data = put16(mem_rdata, op_hsel, '0); n_be = hbe; n_wr = 1'b1; end
      8'h2E, 8'h6E: n_xchg = 1'b1;
      default: ;
    endcase
  end

  wire [HW-1:0] old_half = hsel_q ? mem_rdata[HW-1:0] : mem_rdata[DW-1:HW];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      reg_q     <= '0;
      hsel_q    <= 1'b0;
      full_q    <= 1'b0;
      exc_q     <= 1'b0;
      wr_en     <= 1'b0;
      wr_data   <= '0;
      wr_be     <= '0;
      flag_we   <= 1'b0;
      excess    <= 1'b0;
      reg_we    <= 1'b0;
      reg_wdata <= '0;
    end else begin
      wr_en   <= 1'b0;
      flag_we <= 1'b0;
      excess  <= 1'b0;
      reg_we  <= 1'b0;
      case (st)
        S_IDLE: if (accept) begin
          if (n_xchg) begin
            st     <= S_RD;
            reg_q  <= op_reg;
            hsel_q <= op_hsel;
            full_q <= (op_code == 8'h2E);
            exc_q  <= ~fits;
          end else begin
            wr_en   <= n_wr;
            wr_data <= n_data;
            wr_be   <= n_be;
            flag_we <= n_fwe;
            excess  <= n_fwe & ~fits;
          end
        end
        S_RD: begin
          st      <= S_WR;
          wr_en   <= 1'b1;
          flag_we <= 1'b1;
          excess  <= exc_q;
          reg_we  <= 1'b1;
          if (full_q) begin
            wr_data   <= reg_q;
            wr_be     <= 4'b1111;
            reg_wdata <= mem_rdata;
          end else begin
            wr_data   <= put16(mem_rdata, hsel_q, reg_q[HW-1:0]);
            wr_be     <= hsel_q ? 4'b0011 : 4'b1100;
            reg_wdata <= {{HW{old_half[HW-1]}}, old_half};
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign op_ready = (st == S_IDLE);
  assign lock     = (st != S_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              irq_hold <= 1'b0;
    else if (irq_req & lock) irq_hold <= 1'b1;
    else if (!lock)          irq_hold <= 1'b0;
  end

  assign irq_take = (irq_req | irq_hold) & ~lock;

  a_r9_lock_two: assert property (@(posedge clk) disable iff (!rst_n)
    (lock && $past(lock)) |=> !lock);
  a_r9_lock_min: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lock) |=> lock);
  a_r9_return_locked: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |-> (lock && wr_en && flag_we));
  a_r11_no_take_locked: assert property (@(posedge clk) disable iff (!rst_n)
    irq_take |-> !lock);
  a_r11_deferred: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(lock) && $past(irq_req)) |-> irq_take);
  a_r6_byte_no_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && $countones(wr_be) == 1) |-> !flag_we);
  a_r4_be_shape: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> ($countones(wr_be) != 0 && $countones(wr_be) != 3));
  a_r3_excess_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    excess |-> flag_we);
endmodule

// File: tb/store_xchg_merge_tb.sv
`timescale 1ns/1ps
module store_xchg_merge_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        op_valid = 1'b0;
  logic        op_ready;
  logic [7:0]  op_code = '0;
  logic [31:0] op_reg = '0;
  logic        op_hsel = 1'b0;
  logic [31:0] mem_rdata = '0;
  logic        wr_en, flag_we, excess, reg_we, lock, irq_take;
  logic [31:0] wr_data, reg_wdata;
  logic [3:0]  wr_be;
  logic        irq_req = 1'b0;

  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  store_xchg_merge u_dut (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_ready(op_ready),
    .op_code(op_code), .op_reg(op_reg), .op_hsel(op_hsel), .mem_rdata(mem_rdata),
    .wr_en(wr_en), .wr_data(wr_data), .wr_be(wr_be), .flag_we(flag_we),
    .excess(excess), .reg_we(reg_we), .reg_wdata(reg_wdata), .lock(lock),
    .irq_req(irq_req), .irq_take(irq_take)
  );

  typedef struct packed {
    logic [7:0]  code;
    logic [31:0] rv;
    logic        hs;
    logic [31:0] mem;
    logic        wr;
    logic [31:0] data;
    logic [3:0]  be;
    logic        fwe;
    logic        exc;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t VEC [NV] = '{
    '{8'h26, 32'h12345678, 1'b0, 32'hA1B2C3D4, 1'b1, 32'h12345678, 4'hF, 1'b1, 1'b1},
    '{8'h26, 32'hFFFF8000, 1'b0, 32'hA1B2C3D4, 1'b1, 32'hFFFF8000, 4'hF, 1'b1, 1'b0},
    '{8'h26, 32'h00007FFF, 1'b1, 32'hA1B2C3D4, 1'b1, 32'h00007FFF, 4'hF, 1'b1, 1'b0},
    '{8'h26, 32'h00008000, 1'b0, 32'hA1B2C3D4, 1'b1, 32'h00008000, 4'hF, 1'b1, 1'b1},
    '{8'h66, 32'h12345678, 1'b0, 32'hA1B2C3D4, 1'b1, 32'h5678C3D4, 4'hC, 1'b1, 1'b1},
    '{8'h66, 32'h00000042, 1'b1, 32'hA1B2C3D4, 1'b1, 32'hA1B20042, 4'h3, 1'b1, 1'b0},
    '{8'h64, 32'h12345678, 1'b1, 32'hA1B2C3D4, 1'b1, 32'hA1B21234, 4'h3, 1'b1, 1'b1},
    '{8'h64, 32'hFFFFFFFF, 1'b0, 32'hA1B2C3D4, 1'b1, 32'hFFFFC3D4, 4'hC, 1'b1, 1'b0},
    '{8'h25, 32'h12345678, 1'b0, 32'hA1B2C3D4, 1'b1, 32'h78B2C3D4, 4'h8, 1'b0, 1'b0},
    '{8'h25, 32'h12345678, 1'b1, 32'hA1B2C3D4, 1'b1, 32'hA1B278D4, 4'h2, 1'b0, 1'b0},
    '{8'h65, 32'h12345678, 1'b0, 32'hA1B2C3D4, 1'b1, 32'hA178C3D4, 4'h4, 1'b0, 1'b0},
    '{8'h65, 32'h12345678, 1'b1, 32'hA1B2C3D4, 1'b1, 32'hA1B2C378, 4'h1, 1'b0, 1'b0},
    '{8'h27, 32'h12345678, 1'b0, 32'hA1B2C3D4, 1'b1, 32'h00000000, 4'hF, 1'b0, 1'b0},
    '{8'h67, 32'h12345678, 1'b0, 32'hA1B2C3D4, 1'b1, 32'h0000C3D4, 4'hC, 1'b0, 1'b0},
    '{8'h67, 32'h12345678, 1'b1, 32'hA1B2C3D4, 1'b1, 32'hA1B20000, 4'h3, 1'b0, 1'b0},
    '{8'h00, 32'h12345678, 1'b1, 32'hA1B2C3D4, 1'b0, 32'h00000000, 4'h0, 1'b0, 1'b0}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic string tag_of(input logic [7:0] c);
    case (c)
      8'h26: return "R2";
      8'h66: return "R4";
      8'h64: return "R5";
      8'h25: return "R6";
      8'h65: return "R7";
      8'h27, 8'h67: return "R8";
      default: return "R12";
    endcase
  endfunction

  task automatic run_xchg(input logic [7:0] c, input logic [31:0] rv, input logic hs,
                          input logic [31:0] mem, input logic [31:0] exp_data,
                          input logic [3:0] exp_be, input logic [31:0] exp_ret,
                          input logic exp_exc, input string req);
    @(negedge clk);
    op_valid = 1'b1; op_code = c; op_reg = rv; op_hsel = hs; mem_rdata = mem;
    @(negedge clk);
    op_valid = 1'b0; op_reg = 32'hDEAD0000;
    chk({req, " read phase lock"}, {31'd0, lock}, 32'd1);
    chk({req, " read phase no write"}, {31'd0, wr_en}, 32'd0);
    chk("R12 not ready in exchange", {31'd0, op_ready}, 32'd0);
    @(negedge clk);
    chk({req, " write phase lock"}, {31'd0, lock}, 32'd1);
    chk({req, " write strobe"}, {30'd0, wr_en, reg_we}, 32'd3);
    chk({req, " write data"}, wr_data, exp_data);
    chk({req, " byte enables"}, {28'd0, wr_be}, {28'd0, exp_be});
    chk({req, " return value"}, reg_wdata, exp_ret);
    chk({req, " R3 excess"}, {30'd0, flag_we, excess}, {30'd0, 1'b1, exp_exc});
    @(negedge clk);
    chk({req, " lock released"}, {29'd0, lock, wr_en, reg_we}, 32'd0);
    chk("R12 ready after exchange", {31'd0, op_ready}, 32'd1);
  endtask

  initial begin
    #1000000;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset outputs", {27'd0, wr_en, reg_we, flag_we, excess, lock}, 32'd0);
    chk("R1 reset ready", {31'd0, op_ready}, 32'd1);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 idle after reset", {27'd0, wr_en, reg_we, flag_we, excess, lock}, 32'd0);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      op_valid = 1'b1; op_code = VEC[i].code; op_reg = VEC[i].rv;
      op_hsel = VEC[i].hs; mem_rdata = VEC[i].mem;
      @(negedge clk);
      op_valid = 1'b0;
      chk({tag_of(VEC[i].code), " write strobe"}, {30'd0, wr_en, reg_we}, {30'd0, VEC[i].wr, 1'b0});
      chk({tag_of(VEC[i].code), " flag strobe"}, {31'd0, flag_we}, {31'd0, VEC[i].fwe});
      if (VEC[i].wr) begin
        chk({tag_of(VEC[i].code), " data"}, wr_data, VEC[i].data);
        chk({tag_of(VEC[i].code), " enables"}, {28'd0, wr_be}, {28'd0, VEC[i].be});
      end
      chk("R3 excess value", {31'd0, excess}, {31'd0, VEC[i].exc});
      @(negedge clk);
      chk("R2 single cycle strobe", {31'd0, wr_en}, 32'd0);
    end

    run_xchg(8'h6E, 32'h12345678, 1'b1, 32'hA1B28005, 32'hA1B25678, 4'h3, 32'hFFFF8005, 1'b1, "R9 half xchg lo");
    run_xchg(8'h6E, 32'h00001111, 1'b0, 32'h7FFF0000, 32'h11110000, 4'hC, 32'h00007FFF, 1'b0, "R9 half xchg hi");
    run_xchg(8'h2E, 32'h12345678, 1'b0, 32'hCAFEF00D, 32'h12345678, 4'hF, 32'hCAFEF00D, 1'b1, "R10 full xchg");

    @(negedge clk);
    irq_req = 1'b1;
    #0.5;
    chk("R11 unlocked pass-through", {31'd0, irq_take}, 32'd1);
    @(negedge clk);
    irq_req = 1'b0;
    op_valid = 1'b1; op_code = 8'h6E; op_reg = 32'h1; op_hsel = 1'b0; mem_rdata = 32'h0;
    @(negedge clk);
    op_valid = 1'b0;
    irq_req = 1'b1;
    #0.5;
    chk("R11 blocked in read phase", {31'd0, irq_take}, 32'd0);
    @(negedge clk);
    irq_req = 1'b0;
    #0.5;
    chk("R11 blocked in write phase", {31'd0, irq_take}, 32'd0);
    @(negedge clk);
    chk("R11 deferred request taken", {30'd0, lock, irq_take}, 32'd1);
    @(negedge clk);
    chk("R11 hold cleared", {31'd0, irq_take}, 32'd0);

    @(negedge clk);
    op_valid = 1'b1; op_code = 8'h2E; op_reg = 32'h5; mem_rdata = 32'h9;
    @(negedge clk);
    op_valid = 1'b0;
    rst_n = 1'b0;
    #0.5;
    chk("R1 reset aborts exchange", {28'd0, lock, wr_en, reg_we, op_ready}, 32'd1);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk("R1 stays idle after reset", {29'd0, lock, wr_en, reg_we}, 32'd0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule